// File: doc/BRIEF.md
# SD Command Issue Unit

This block launches one card command at a time. Software loads a 32-bit argument and then writes a command word whose top trigger bit is set. The unit presents the command index and argument on a parallel card-side request channel. It then waits on a response channel that returns a length code, an error flag and up to sixteen response bytes.

The unit checks the returned length against the response type the command asked for. A good response is arranged into four 32-bit response registers. A failure sets a flag inside the stored command word and a timeout bit in the status register. A good busy-wait command can raise an interrupt request when that interrupt is enabled. Serial line signalling, CRC and clock division are not part of this block.

Both card channels use valid/ready. The request holds `cmd_valid` with a steady index and argument until `cmd_ready` is seen. The unit raises `rsp_ready` only after the request has been taken, and it keeps it high until a response arrives. The card may stall either channel for any number of cycles. The register port is plain: a write takes effect at the clock edge, and a read is combinational on the address. Address map: 0 command word, 1 argument, 2 status, 3 configuration, 4 to 7 response words 0 to 3.

Top module: `sd_cmd_issue`

## Requirements
- R1: After reset, every register reads 0, `cmd_valid` and `rsp_ready` are low, and `busy_irq` is low.
- R2: A command-word write with bit 15 set, made while idle, starts exactly one request carrying index bits 5:0 and the stored argument. The same write with bit 15 clear only stores the word.
- R3: `cmd_valid` stays high with a stable index and argument until `cmd_ready`. `rsp_ready` is high only after the request is accepted and until the response handshake. The two are never high together.
- R4: While a command is outstanding, command-word bit 15 reads 1. It clears on completion, and the other written bits are kept.
- R5: Writes to the command word or the argument while a command is outstanding are ignored.
- R6: A command fails when `rsp_err` is set. When bit 10 (no-response) is clear, it also fails for length code 0 (no bytes), code 3 (unsupported length), or code 1 (4 bytes) with bit 9 (long) set. Code 2 means 16 bytes.
- R7: On failure, command-word bit 14 and status bit 6 are set, and the response words keep their old values.
- R8: A good 4-byte response puts `rsp_data[127:96]` (byte 0 most significant) into word 0 and clears words 1 to 3.
- R9: A good 16-byte response puts `rsp_data[32i+31:32i]` into word i, so word 0 holds bytes 12..15 and word 3 holds bytes 0..3.
- R10: A good no-response command leaves the response words unchanged for any length code.
- R11: A good command with bit 11 (busy-wait) sets status bit 10 only when configuration bit 10 is set. `busy_irq` equals status bit 10.
- R12: Writing the status register clears each bit written as 1. A bit set by completion in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_valid | output | 1 | Request valid toward the card |
| cmd_ready | input | 1 | Card accepts the request |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Card response valid |
| rsp_ready | output | 1 | Unit accepts a response |
| rsp_len | input | 2 | Length code: 0 none, 1 four bytes, 2 sixteen bytes, 3 unsupported |
| rsp_err | input | 1 | Card reports an error |
| rsp_data | input | 128 | Response bytes, byte 0 at bits 127:120 |
| busy_irq | output | 1 | Busy-wait interrupt request |

## Verification
Software clearing the status register can land in the same cycle as command completion setting a status bit. The bench provokes this in two steps. A failing command first leaves the timeout bit set. The bench then finishes a busy-wait command with the interrupt enabled, driving the response handshake and an all-ones status write in the same cycle. The check passes when the status reads exactly the busy bit: the stale timeout bit is cleared and the newly set busy bit survives.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int CW_TRIG  = 15;
  localparam int CW_FAIL  = 14;
  localparam int CW_BUSYW = 11;
  localparam int CW_NORSP = 10;
  localparam int CW_LONG  = 9;
  localparam int ST_BUSY  = 10;
  localparam int ST_TOUT  = 6;
  localparam int CF_BUSYEN = 10;

  typedef enum logic [1:0] {
    LEN_NONE  = 2'd0,
    LEN_SHORT = 2'd1,
    LEN_LONG  = 2'd2,
    LEN_BAD   = 2'd3
  } rsp_len_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmd_ready,
  input  logic rsp_valid,
  output logic cmd_valid,
  output logic rsp_ready,
  output logic busy,
  output logic done
);
  import sd_cmd_pkg::*;

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE: if (start)     state_d = SQ_REQ;
      SQ_REQ:  if (cmd_ready) state_d = SQ_WAIT;
      SQ_WAIT: if (rsp_valid) state_d = SQ_IDLE;
      default:                state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_valid = (state_q == SQ_REQ);
  assign rsp_ready = (state_q == SQ_WAIT);
  assign busy      = (state_q != SQ_IDLE);
  assign done      = rsp_ready && rsp_valid;

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_valid);
  assert_rsp_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_ready) |-> $past(cmd_valid && cmd_ready));
  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, rsp_ready}));
endmodule

// File: rtl/sd_rsp_decode.sv
module sd_rsp_decode #(
  parameter int WORD_W    = 32,
  parameter int RSP_WORDS = 4,
  localparam int DATA_W   = WORD_W * RSP_WORDS
) (
  input  logic                              no_rsp,
  input  logic                              want_long,
  input  sd_cmd_pkg::rsp_len_e              len,
  input  logic                              err,
  input  logic [DATA_W-1:0]                 data,
  output logic                              fail,
  output logic                              store,
  output logic [RSP_WORDS-1:0][WORD_W-1:0]  words
);
  import sd_cmd_pkg::*;

  logic len_bad;
  logic is_short;

  assign is_short = (len == LEN_SHORT);
  assign len_bad  = (len == LEN_NONE) || (len == LEN_BAD) || (is_short && want_long);
  assign fail     = err || (!no_rsp && len_bad);
  assign store    = !fail && !no_rsp;

  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_word
    if (i == 0) begin : g_first
      assign words[i] = is_short ? data[DATA_W-1 -: WORD_W] : data[0 +: WORD_W];
    end else begin : g_rest
      assign words[i] = is_short ? '0 : data[i*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue #(
  parameter int WORD_W    = 32,
  parameter int RSP_WORDS = 4,
  parameter int IDX_W     = 6,
  localparam int DATA_W   = WORD_W * RSP_WORDS,
  localparam int SEL_W    = $clog2(RSP_WORDS),
  localparam int ADDR_W   = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [IDX_W-1:0]  cmd_index,
  output logic [WORD_W-1:0] cmd_arg,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_len,
  input  logic              rsp_err,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy_irq
);
  import sd_cmd_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ARG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(3);

  logic [WORD_W-1:0] cmd_q, arg_q;
  logic              busy_en_q;
  logic              st_busy_q, st_tout_q;
  logic [RSP_WORDS-1:0][WORD_W-1:0] rsp_q;

  logic busy, done, fail, store, start, cmd_we, arg_we, stat_we;
  logic set_busy, set_tout;
  logic [RSP_WORDS-1:0][WORD_W-1:0] words;
  rsp_len_e len_c;

  assign len_c   = rsp_len_e'(rsp_len);
  assign cmd_we  = reg_we && (reg_addr == A_CMD) && !busy;
  assign arg_we  = reg_we && (reg_addr == A_ARG) && !busy;
  assign stat_we = reg_we && (reg_addr == A_STAT);
  assign start   = cmd_we && reg_wdata[CW_TRIG];

  sd_cmd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .cmd_valid (cmd_valid),
    .rsp_ready (rsp_ready),
    .busy      (busy),
    .done      (done)
  );

  sd_rsp_decode #(.WORD_W(WORD_W), .RSP_WORDS(RSP_WORDS)) u_dec (
    .no_rsp    (cmd_q[CW_NORSP]),
    .want_long (cmd_q[CW_LONG]),
    .len       (len_c),
    .err       (rsp_err),
    .data      (rsp_data),
    .fail      (fail),
    .store     (store),
    .words     (words)
  );

  assign set_tout = done && fail;
  assign set_busy = done && !fail && cmd_q[CW_BUSYW] && busy_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_we) begin
      cmd_q <= reg_wdata;
    end else if (done) begin
      cmd_q[CW_TRIG] <= 1'b0;
      if (fail) cmd_q[CW_FAIL] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      arg_q <= '0;
    else if (arg_we) arg_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   busy_en_q <= 1'b0;
    else if (reg_we && (reg_addr == A_CFG))       busy_en_q <= reg_wdata[CF_BUSYEN];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_busy_q <= 1'b0;
      st_tout_q <= 1'b0;
    end else begin
      st_busy_q <= set_busy || (st_busy_q && !(stat_we && reg_wdata[ST_BUSY]));
      st_tout_q <= set_tout || (st_tout_q && !(stat_we && reg_wdata[ST_TOUT]));
    end
  end

  for (genvar i = 0; i < RSP_WORDS; i++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (!rst_n)             rsp_q[i] <= '0;
      else if (done && store) rsp_q[i] <= words[i];
    end
  end

  assign cmd_index = cmd_q[IDX_W-1:0];
  assign cmd_arg   = arg_q;
  assign busy_irq  = st_busy_q;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[ADDR_W-1]) begin
      reg_rdata = rsp_q[reg_addr[SEL_W-1:0]];
    end else begin
      unique case (reg_addr)
        A_CMD:  reg_rdata = cmd_q;
        A_ARG:  reg_rdata = arg_q;
        A_STAT: begin
          reg_rdata[ST_BUSY] = st_busy_q;
          reg_rdata[ST_TOUT] = st_tout_q;
        end
        A_CFG:  reg_rdata[CF_BUSYEN] = busy_en_q;
        default: reg_rdata = '0;
      endcase
    end
  end

  assert_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cmd_q[CW_TRIG]);
  assert_trig_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !cmd_q[CW_TRIG]);
  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(cmd_q) && $stable(arg_q)));
  assert_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> ($stable(cmd_index) && $stable(cmd_arg)));
  assert_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |=> (cmd_q[CW_FAIL] && st_tout_q && $stable(rsp_q)));
  assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_irq) |-> $past(done && !fail));
  assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |=> st_tout_q);
endmodule

// File: tb/sd_cmd_issue_tb.sv
module sd_cmd_issue_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         reg_we = 0;
  logic [2:0]   reg_addr = 0;
  logic [31:0]  reg_wdata = 0;
  logic [31:0]  reg_rdata;
  logic         cmd_valid;
  logic         cmd_ready = 0;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic         rsp_valid = 0;
  logic         rsp_ready;
  logic [1:0]   rsp_len = 0;
  logic         rsp_err = 0;
  logic [127:0] rsp_data = 0;
  logic         busy_irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_rsp [4];

  always #5 clk = ~clk;

  sd_cmd_issue u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
    .rsp_err(rsp_err), .rsp_data(rsp_data), .busy_irq(busy_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input logic [31:0] cw, input logic [31:0] arg, input logic [1:0] len,
                     input logic err, input logic [127:0] data,
                     input logic poke, input logic clr_same);
    logic [31:0] v;
    wr(3'd1, arg);
    wr(3'd0, cw);
    chk("R2 request valid", {31'b0, cmd_valid}, 32'd1);
    chk("R2 request index", {26'b0, cmd_index}, {26'b0, cw[5:0]});
    chk("R2 request arg", cmd_arg, arg);
    @(negedge clk);
    chk("R3 valid held while stalled", {31'b0, cmd_valid}, 32'd1);
    chk("R3 no rsp_ready before accept", {31'b0, rsp_ready}, 32'd0);
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
    chk("R3 rsp_ready after accept", {31'b0, rsp_ready}, 32'd1);
    rd(3'd0, v);
    chk("R4 trigger reads 1 while pending", {31'b0, v[15]}, 32'd1);
    if (poke) begin
      wr(3'd0, 32'h0000_8015);
      wr(3'd1, 32'hDEAD_0000);
      rd(3'd0, v);
      chk("R5 command write ignored", v, cw);
      rd(3'd1, v);
      chk("R5 argument write ignored", v, arg);
      chk("R5 no second request", {31'b0, cmd_valid}, 32'd0);
    end
    rsp_valid = 1; rsp_len = len; rsp_err = err; rsp_data = data;
    if (clr_same) begin
      reg_we = 1; reg_addr = 3'd2; reg_wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    rsp_valid = 0; reg_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 register reset value", v, 32'd0);
    end
    chk("R1 no request after reset", {31'b0, cmd_valid}, 32'd0);
    chk("R1 no rsp_ready after reset", {31'b0, rsp_ready}, 32'd0);
    chk("R1 irq low after reset", {31'b0, busy_irq}, 32'd0);
    for (int i = 0; i < 4; i++) exp_rsp[i] = 32'd0;

    wr(3'd0, 32'h0000_0E05);
    repeat (3) begin
      @(negedge clk);
      chk("R2 no request without trigger", {31'b0, cmd_valid}, 32'd0);
    end
    rd(3'd0, v);
    chk("R2 word stored without trigger", v, 32'h0000_0E05);

    for (int k = 0; k < 128; k++) begin
      logic [1:0]   len;
      logic         nr, lg, bw, en, er, fl;
      logic [31:0]  cw, arg, st;
      logic [127:0] data;
      len = k[1:0]; nr = k[2]; lg = k[3]; bw = k[4]; en = k[5]; er = k[6];
      for (int i = 0; i < 4; i++)
        data[i*32 +: 32] = 32'(k + 1) * 32'h9E37_79B1 + 32'(i) * 32'h0123_4567;
      cw  = 32'h8000 | (32'(bw) << 11) | (32'(nr) << 10) | (32'(lg) << 9)
          | (k[0] ? 32'h40 : 32'h80) | 32'(k % 64);
      arg = 32'hA500_0000 + 32'(k) * 32'h0001_0203;
      wr(3'd2, 32'hFFFF_FFFF);
      wr(3'd3, 32'(en) << 10);
      run(cw, arg, len, er, data, (k % 16) == 3, 1'b0);
      fl = er || (!nr && (len == 2'd0 || len == 2'd3 || (len == 2'd1 && lg)));
      if (!fl && !nr) begin
        if (len == 2'd1) begin
          exp_rsp[0] = data[127:96];
          for (int i = 1; i < 4; i++) exp_rsp[i] = 32'd0;
        end else begin
          for (int i = 0; i < 4; i++) exp_rsp[i] = data[i*32 +: 32];
        end
      end
      rd(3'd0, v);
      chk("R4/R7 command word after completion", v, (cw & ~32'h8000) | (fl ? 32'h4000 : 32'h0));
      st = (fl ? 32'h40 : 32'h0) | ((!fl && bw && en) ? 32'h400 : 32'h0);
      rd(3'd2, v);
      chk("R6/R7/R11 status after completion", v, st);
      chk("R11 irq follows busy status", {31'b0, busy_irq}, {31'b0, st[10]});
      for (int i = 0; i < 4; i++) begin
        rd(3'(4 + i), v);
        chk(fl ? "R7 words kept on failure" : (nr ? "R10 words kept without response"
            : (len == 2'd1 ? "R8 short response word" : "R9 long response word")),
            v, exp_rsp[i]);
      end
    end

    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_0400);
    run(32'h0000_8011, 32'h1, 2'd0, 1'b0, 128'd0, 1'b0, 1'b0);
    rd(3'd2, v);
    chk("R7 timeout set before clash", v, 32'h40);
    run(32'h0000_8812, 32'h2, 2'd1, 1'b0, {32'hCAFE_F00D, 96'd0}, 1'b0, 1'b1);
    rd(3'd2, v);
    chk("R12 completion set survives same-cycle clear", v, 32'h400);
    chk("R11 irq after clash", {31'b0, busy_irq}, 32'd1);
    rd(3'd4, v);
    chk("R8 short word in clash run", v, 32'hCAFE_F00D);
    wr(3'd2, 32'h0000_0040);
    rd(3'd2, v);
    chk("R12 clearing other bit keeps busy", v, 32'h400);
    wr(3'd2, 32'h0000_0400);
    rd(3'd2, v);
    chk("R12 busy bit cleared by write", v, 32'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule